// File: doc/BRIEF.md
# CAN Receive Message FIFO

This block is the receive store of a CAN controller. The protocol engine writes the bytes of each accepted frame one at a time into a 64-byte circular data memory. It then closes the frame with an end-of-frame strobe. At that strobe the block pushes one entry onto a 32-entry side queue. The entry holds the number of bytes kept for that frame and a flag that says whether any of the frame's bytes were lost because storage was full. The length is counted inside the block from the bytes it actually accepted. A remote-request frame, for which the engine writes only header bytes, is therefore kept as a header-only frame with the correct length. Standard frames carry 2 header bytes and extended frames 5, followed by up to 8 data bytes.

On the read side the oldest complete frame is visible through a random-access port. The reader gives a byte offset from the start of that frame, and the byte comes back combinationally, with the address taken modulo 64. The stored length and the loss flag of the oldest frame are shown beside it. A release command drops the oldest frame: the read start moves forward by its length, and the side-queue read index moves forward by one. The block also reports how many bytes it holds, counting any partly written frame, and how many complete frames are waiting. A synchronous reset clears every pointer, counter and flag.

Top module: `rxf_msg_fifo`

## Requirements
- R1: While `rst` is high at a rising edge, the block is cleared at that edge: `byte_cnt` = 0, `frame_cnt` = 0, `head_len` = 0 and `head_ovr` = 0.
- R2: A byte write (`wr_en`=1) is accepted when `byte_cnt` < 64 and `frame_cnt` < 32. It raises `byte_cnt` by one after the edge, and the byte is stored at the next free position of the ring.
- R3: `frame_end`=1 with `frame_cnt` < 32 pushes one entry after the edge. The entry's length is the number of bytes accepted since the previous `frame_end`, counting a byte accepted in the same cycle, and `frame_cnt` rises by one.
- R4: With `frame_cnt` > 0, `rd_byte` combinationally shows the stored byte at offset `rd_off` from the oldest frame's first byte. `head_len` and `head_ovr` show that frame's entry.
- R5: `release_req`=1 with `frame_cnt` > 0 frees the oldest frame after the edge. `byte_cnt` falls by its length, `frame_cnt` falls by one, and the next frame becomes the oldest.
- R6: `release_req`=1 with `frame_cnt` = 0 has no effect on `byte_cnt`, `frame_cnt` or the stored data.
- R7: A byte write while `byte_cnt` = 64 is discarded and `byte_cnt` stays at 64. The entry later pushed for that frame has `head_ovr` = 1, and its length counts only the stored bytes.
- R8: Write, end-of-frame and release in the same cycle all act. Each count changes by the sum of its increments and decrements. Acceptance and the full tests use the counts from before the edge.
- R9: Data addresses wrap modulo 64 and side-queue indices wrap modulo 32. A frame that crosses the end of the ring reads back in order.
- R10: While `frame_cnt` = 32, `frame_end` is discarded and `frame_cnt` stays at 32. Byte writes are also discarded and counted as lost. The pending length and loss flag are cleared by that `frame_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write one byte of the frame being received |
| wr_byte | input | 8 | Byte to write |
| frame_end | input | 1 | Close the current frame and push its entry |
| release_req | input | 1 | Free the oldest complete frame |
| rd_off | input | 6 | Byte offset from the oldest frame's first byte |
| rd_byte | output | 8 | Byte at `rd_off` within the oldest frame |
| head_len | output | 7 | Stored byte count of the oldest frame (0 when none) |
| head_ovr | output | 1 | Oldest frame lost bytes to a full store (0 when none) |
| byte_cnt | output | 7 | Bytes held, including a partly written frame |
| frame_cnt | output | 6 | Complete frames held |

## Verification
Every count and every entry field changes at the rising edge that samples the command, so it is due one edge after the stimulus. `rd_byte` follows `rd_off` within the same cycle. The bench drives all inputs on the falling edge, lets one rising edge pass, and compares the counts and the head entry at the next falling edge. It then steps `rd_off` through the first, the last and a random offset of the oldest frame, with a short settle delay before each compare. The expected state comes from a queue-based model that is updated once per step, using the counts from before that step. This matches the rule that acceptance depends on the state before the edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int unsigned RXF_BYTE_W     = 8;
    localparam int unsigned RXF_DATA_DEPTH = 64;
    localparam int unsigned RXF_INFO_DEPTH = 32;
endpackage

// File: rtl/rxf_ram.sv
module rxf_ram #(
    parameter  int unsigned W     = 8,
    parameter  int unsigned DEPTH = 64,
    localparam int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rxf_msg_fifo.sv
module rxf_msg_fifo import rxf_pkg::*; #(
    parameter  int unsigned BYTE_W     = RXF_BYTE_W,
    parameter  int unsigned DATA_DEPTH = RXF_DATA_DEPTH,
    parameter  int unsigned INFO_DEPTH = RXF_INFO_DEPTH,
    localparam int unsigned DAW        = $clog2(DATA_DEPTH),
    localparam int unsigned IAW        = $clog2(INFO_DEPTH),
    localparam int unsigned CW         = DAW + 1,
    localparam int unsigned FW         = IAW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              frame_end,
    input  logic              release_req,
    input  logic [DAW-1:0]    rd_off,
    output logic [BYTE_W-1:0] rd_byte,
    output logic [CW-1:0]     head_len,
    output logic              head_ovr,
    output logic [CW-1:0]     byte_cnt,
    output logic [FW-1:0]     frame_cnt
);
    localparam int unsigned IW = CW + 1;   // entry: {lost flag, length}

    typedef struct packed {
        logic [DAW-1:0] wptr;    // next free data slot
        logic [DAW-1:0] rptr;    // first byte of oldest frame
        logic [CW-1:0]  bcnt;    // bytes held
        logic [FW-1:0]  iwr;     // entry write index (extra wrap bit)
        logic [FW-1:0]  ird;     // entry read index (extra wrap bit)
        logic [CW-1:0]  plen;    // bytes accepted for the open frame
        logic           povr;    // open frame lost a byte
    } state_t;

    state_t s_q, s_d;

    logic [FW-1:0] fcnt;
    logic          info_full, data_full, acc, drop, rel_ok, push;
    logic [CW-1:0] new_len, rel_len;
    logic [IW-1:0] info_wdata, info_rdata;

    assign fcnt       = s_q.iwr - s_q.ird;
    assign info_full  = (fcnt == FW'(INFO_DEPTH));
    assign data_full  = (s_q.bcnt == CW'(DATA_DEPTH));
    assign acc        = wr_en & ~data_full & ~info_full;
    assign drop       = wr_en & ~acc;
    assign rel_ok     = release_req & (fcnt != '0);
    assign push       = frame_end & ~info_full;
    assign new_len    = s_q.plen + CW'(acc);
    assign info_wdata = {s_q.povr | drop, new_len};
    assign rel_len    = rel_ok ? info_rdata[CW-1:0] : '0;

    always_comb begin
        s_d      = s_q;
        s_d.wptr = s_q.wptr + DAW'(acc);
        s_d.rptr = s_q.rptr + rel_len[DAW-1:0];
        s_d.bcnt = s_q.bcnt + CW'(acc) - rel_len;
        s_d.iwr  = s_q.iwr + FW'(push);
        s_d.ird  = s_q.ird + FW'(rel_ok);
        if (frame_end) begin
            s_d.plen = '0;
            s_d.povr = 1'b0;
        end else begin
            s_d.plen = new_len;
            s_d.povr = s_q.povr | drop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    rxf_ram #(.W(BYTE_W), .DEPTH(DATA_DEPTH)) u_data (
        .clk   (clk),
        .we    (acc),
        .waddr (s_q.wptr),
        .wdata (wr_byte),
        .raddr (s_q.rptr + rd_off),
        .rdata (rd_byte)
    );

    rxf_ram #(.W(IW), .DEPTH(INFO_DEPTH)) u_info (
        .clk   (clk),
        .we    (push),
        .waddr (s_q.iwr[IAW-1:0]),
        .wdata (info_wdata),
        .raddr (s_q.ird[IAW-1:0]),
        .rdata (info_rdata)
    );

    assign head_len  = (fcnt != '0) ? info_rdata[CW-1:0] : '0;
    assign head_ovr  = (fcnt != '0) ? info_rdata[CW]     : 1'b0;
    assign byte_cnt  = s_q.bcnt;
    assign frame_cnt = fcnt;
endmodule

// File: rtl/rxf_msg_fifo_chk.sv
module rxf_msg_fifo_chk #(
    parameter  int unsigned DATA_DEPTH = 64,
    parameter  int unsigned INFO_DEPTH = 32,
    localparam int unsigned CW = $clog2(DATA_DEPTH) + 1,
    localparam int unsigned FW = $clog2(INFO_DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          frame_end,
    input logic          release_req,
    input logic [CW-1:0] byte_cnt,
    input logic [FW-1:0] frame_cnt,
    input logic [CW-1:0] head_len,
    input logic          head_ovr
);
    logic rst_seen;
    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen == 1'b1) begin
            AST_RESET_CLEAR: assert (byte_cnt == '0 && frame_cnt == '0 && head_len == '0 && !head_ovr); // R1
        end
    end

    AST_BYTE_CAP: assert property (@(posedge clk) disable iff (rst)
        byte_cnt <= CW'(DATA_DEPTH)); // R7
    AST_FRAME_CAP: assert property (@(posedge clk) disable iff (rst)
        frame_cnt <= FW'(INFO_DEPTH)); // R10
    AST_BYTE_INC: assert property (@(posedge clk) disable iff (rst)
        (wr_en && byte_cnt < CW'(DATA_DEPTH) && frame_cnt < FW'(INFO_DEPTH) && !release_req)
        |=> byte_cnt == CW'($past(byte_cnt) + 1'b1)); // R2
    AST_FRAME_INC: assert property (@(posedge clk) disable iff (rst)
        (frame_end && frame_cnt < FW'(INFO_DEPTH) && !release_req)
        |=> frame_cnt == FW'($past(frame_cnt) + 1'b1)); // R3
    AST_REL_DEC: assert property (@(posedge clk) disable iff (rst)
        (release_req && frame_cnt != '0 && !frame_end)
        |=> frame_cnt == FW'($past(frame_cnt) - 1'b1)); // R5
    AST_EMPTY_REL: assert property (@(posedge clk) disable iff (rst)
        (release_req && frame_cnt == '0 && !frame_end && !wr_en)
        |=> (frame_cnt == '0 && $stable(byte_cnt))); // R6
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (byte_cnt == CW'(DATA_DEPTH) && !release_req)
        |=> byte_cnt == CW'(DATA_DEPTH)); // R7
    AST_INFO_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (frame_cnt == FW'(INFO_DEPTH) && !release_req)
        |=> (frame_cnt == FW'(INFO_DEPTH) && $stable(byte_cnt))); // R10
endmodule

bind rxf_msg_fifo rxf_msg_fifo_chk #(.DATA_DEPTH(DATA_DEPTH), .INFO_DEPTH(INFO_DEPTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .frame_end   (frame_end),
    .release_req (release_req),
    .byte_cnt    (byte_cnt),
    .frame_cnt   (frame_cnt),
    .head_len    (head_len),
    .head_ovr    (head_ovr)
);

// File: tb/sim_rxf_msg_fifo.sv
`timescale 1ns/10ps
module sim_rxf_msg_fifo;
    localparam int DD = 64;
    localparam int ID = 32;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_byte = '0;
    logic       frame_end = 1'b0;
    logic       release_req = 1'b0;
    logic [5:0] rd_off = '0;
    logic [7:0] rd_byte;
    logic [6:0] head_len;
    logic       head_ovr;
    logic [6:0] byte_cnt;
    logic [5:0] frame_cnt;

    int checks = 0;
    int errors = 0;

    // model state
    logic [7:0] bq[$];
    int         fl[$];
    bit         fo[$];
    int         pl = 0;
    bit         po = 0;

    always #4 clk = ~clk;

    rxf_msg_fifo u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte),
        .frame_end(frame_end), .release_req(release_req), .rd_off(rd_off),
        .rd_byte(rd_byte), .head_len(head_len), .head_ovr(head_ovr),
        .byte_cnt(byte_cnt), .frame_cnt(frame_cnt)
    );

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic void model_step(bit we, logic [7:0] b, bit fe, bit rel);
        int  nf  = fl.size();
        int  nb  = bq.size();
        bit  acc = we && nb < DD && nf < ID;
        bit  drp = we && !acc;
        if (rel && nf > 0) begin
            for (int k = 0; k < fl[0]; k++) void'(bq.pop_front());
            void'(fl.pop_front());
            void'(fo.pop_front());
        end
        if (acc) bq.push_back(b);
        if (fe) begin
            if (nf < ID) begin
                fl.push_back(pl + int'(acc));
                fo.push_back(po | drp);
            end
            pl = 0;
            po = 0;
        end else begin
            pl = pl + int'(acc);
            po = po | drp;
        end
    endfunction

    task automatic step(bit we, logic [7:0] b, bit fe, bit rel);
        wr_en = we; wr_byte = b; frame_end = fe; release_req = rel;
        @(posedge clk);
        model_step(we, b, fe, rel);
        @(negedge clk);
        wr_en = 0; frame_end = 0; release_req = 0;
    endtask

    task automatic check_all(string tag);
        chk(tag, "byte_cnt", int'(byte_cnt), bq.size());
        chk(tag, "frame_cnt", int'(frame_cnt), fl.size());
        if (fl.size() > 0) begin
            chk(tag, "head_len", int'(head_len), fl[0]);
            chk(tag, "head_ovr", int'(head_ovr), int'(fo[0]));
            if (fl[0] > 0) begin
                for (int j = 0; j < 3; j++) begin
                    int off;
                    off = (j == 0) ? 0 : (j == 1) ? fl[0] - 1 : int'($urandom_range(fl[0] - 1, 0));
                    rd_off = 6'(off);
                    #0.1;
                    chk(tag, "rd_byte", int'(rd_byte), int'(bq[off]));
                end
            end
        end else begin
            chk(tag, "head_ovr", int'(head_ovr), 0);
        end
    endtask

    task automatic put_frame(int n, string tag);
        for (int k = 0; k < n; k++) step(1, 8'($urandom), (k == n - 1), 0);
        check_all(tag);
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'h5eed_0c4a));
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: cleared state
        chk("R1", "byte_cnt", int'(byte_cnt), 0);
        chk("R1", "frame_cnt", int'(frame_cnt), 0);
        chk("R1", "head_len", int'(head_len), 0);
        chk("R1", "head_ovr", int'(head_ovr), 0);

        // R2: partial frame counts bytes
        step(1, 8'hA5, 0, 0);
        check_all("R2");
        // R3: header-only (remote-style) frame closes with same-cycle byte
        step(1, 8'h3C, 1, 0);
        check_all("R3");
        // R4: extended header plus 8 data bytes
        put_frame(13, "R4");
        // R5: release oldest
        step(0, 0, 0, 1);
        check_all("R5");
        step(0, 0, 0, 1);
        check_all("R5");
        // R6: release with nothing held
        step(0, 0, 0, 1);
        check_all("R6");
        // R7: overfill one frame
        for (int k = 0; k < 70; k++) step(1, 8'($urandom), 0, 0);
        check_all("R7");
        step(1, 8'h11, 1, 0);
        check_all("R7");
        step(0, 0, 0, 1);
        check_all("R7");
        // R9: frames crossing the end of the ring
        put_frame(40, "R9");
        step(0, 0, 0, 1);
        put_frame(40, "R9");
        put_frame(9, "R9");
        step(0, 0, 0, 1);
        check_all("R9");
        // R8: write + close + release in one cycle
        step(1, 8'h77, 0, 0);
        step(1, 8'h78, 1, 1);
        check_all("R8");
        step(0, 0, 0, 1);
        check_all("R8");
        // R10: fill the entry queue with empty frames
        for (int k = 0; k < ID; k++) step(0, 0, 1, 0);
        check_all("R10");
        step(0, 0, 1, 0);
        check_all("R10");
        step(1, 8'h42, 0, 0);
        check_all("R10");
        step(0, 0, 1, 0);
        step(0, 0, 0, 1);
        step(0, 0, 1, 0);
        check_all("R10");
        for (int k = 0; k < ID + 2; k++) step(0, 0, 0, 1);
        check_all("R10");

        // R8: random mixes, release rare then frequent
        for (int ph = 0; ph < 2; ph++) begin
            for (int k = 0; k < 1500; k++) begin
                bit we, fe, rel;
                we  = ($urandom_range(99, 0) < 65);
                fe  = ($urandom_range(99, 0) < 10);
                rel = ($urandom_range(99, 0) < ((ph == 0) ? 6 : 18));
                step(we, 8'($urandom), fe, rel);
                check_all("R8");
            end
        end
        summary();
    end
endmodule